// File: doc/BRIEF.md
# Fixed-Priority Pending Interrupt Selector

This block sits between the asynchronous interrupt sources of a processor core and its exception sequencer. It keeps a pending bit for each of twelve sources. Each cycle it can offer one of them to the core as a registered one-hot grant with a cause code. The pending vector sets on per-source pulses and clears on per-source clear pulses.

Candidates fall into three gating groups:
- System reset and machine check are always eligible.
- The critical external input needs the critical-enable bit of the core's state word.
- Every source from the watchdog down needs the external-enable bit.

Among the eligible candidates the lowest index wins. A grant stays on the outputs until the core answers with a take pulse.

Each source has its own rule for whether the take clears its pending bit:
- The critical external and external inputs are level-like, so their bits survive delivery.
- The decrementer bit is cleared only when the clear-on-delivery configuration input is high.
- Every other bit is cleared by its take.

A summary request line stays high while any pending bit is set.

Top module: `prio_irq_select`

## Requirements
- R1: After reset, every pending bit is clear, grant_o is zero, cause_o is zero and req_o is low.
- R2: A set pulse on a source makes req_o high on the next cycle. req_o is low in any cycle in which no pending bit is set.
- R3: Source indices give the priority, highest first: 0 reset, 1 machine check, 2 critical external, 3 watchdog, 4 critical doorbell, 5 fixed-interval timer, 6 programmable-interval timer, 7 decrementer, 8 external, 9 doorbell, 10 performance monitor, 11 thermal. The grant is one-hot at the winner's index and cause_o equals that index.
- R4: Sources 0 and 1 are granted whatever the enable bits are.
- R5: Source 2 is granted only while crit_en_i is 1.
- R6: Sources 3 to 11 are granted only while ext_en_i is 1.
- R7: A grant is loaded one cycle after its pending bit becomes visible. It then stays unchanged until take_i, even if a higher-priority source becomes pending.
- R8: take_i during a grant clears grant_o on the next cycle. The selector chooses again on the cycle after that, from the updated pending bits.
- R9: Taking source 2 or source 8 leaves its pending bit set.
- R10: Taking source 7 clears its pending bit only if decr_clr_cfg_i is 1.
- R11: Taking any of sources 0, 1, 3, 4, 5, 6, 9, 10, 11 clears its pending bit.
- R12: A set pulse for a source wins over a take-driven clear or a clear pulse for that source in the same cycle.
- R13: take_i while grant_o is zero has no effect. A clear pulse on a source with no set pulse clears that source's pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_set_i | input | 12 | Per-source set pulses |
| src_clr_i | input | 12 | Per-source clear pulses from the sources |
| take_i | input | 1 | Core accepts the current grant |
| crit_en_i | input | 1 | Critical-enable bit of the state word |
| ext_en_i | input | 1 | External-enable bit of the state word |
| decr_clr_cfg_i | input | 1 | Decrementer clear-on-delivery configuration |
| grant_o | output | 12 | Registered one-hot grant |
| cause_o | output | CAUSE_W | Cause code of the grant (source index) |
| req_o | output | 1 | Any source pending |

## Verification
The timing chain runs from a set pulse through two register stages:
- A set pulse is visible on req_o one clock later.
- The resulting grant appears one clock after that.
- A take empties grant_o at the next clock, and the re-chosen grant follows a clock later.

The bench drives inputs one time unit after a rising edge and samples just after the following edge. Every expectation is placed at the exact edge count above.

The bench sweeps:
- every source under all four enable combinations and both decrementer settings;
- every ordered pair of sources for priority;
- directed cases for grant holding, a set colliding with a take, and take or clear pulses with nothing granted.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

   localparam int unsigned SRC_N = 12;

   localparam int unsigned IX_RESET  = 0;
   localparam int unsigned IX_MCHK   = 1;
   localparam int unsigned IX_CEXT   = 2;
   localparam int unsigned IX_WDOG   = 3;
   localparam int unsigned IX_CDBELL = 4;
   localparam int unsigned IX_FIT    = 5;
   localparam int unsigned IX_PIT    = 6;
   localparam int unsigned IX_DECR   = 7;
   localparam int unsigned IX_EXT    = 8;
   localparam int unsigned IX_DBELL  = 9;
   localparam int unsigned IX_PERF   = 10;
   localparam int unsigned IX_THERM  = 11;

   typedef enum logic [1:0] {
      GATE_NONE = 2'd0,
      GATE_CRIT = 2'd1,
      GATE_EXT  = 2'd2
   } gate_e;

   typedef enum logic [1:0] {
      DROP_ALWAYS = 2'd0,
      DROP_NEVER  = 2'd1,
      DROP_CFG    = 2'd2
   } drop_e;

   function automatic gate_e gate_of(input int unsigned idx);
      if (idx == IX_RESET || idx == IX_MCHK) return GATE_NONE;
      if (idx == IX_CEXT) return GATE_CRIT;
      return GATE_EXT;
   endfunction

   function automatic drop_e drop_of(input int unsigned idx);
      if (idx == IX_CEXT || idx == IX_EXT) return DROP_NEVER;
      if (idx == IX_DECR) return DROP_CFG;
      return DROP_ALWAYS;
   endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int unsigned N = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   input  logic [N-1:0] drop_i,
   output logic [N-1:0] pend_o
);

   for (genvar g = 0; g < N; g++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n) pend_o[g] <= 1'b0;
         else        pend_o[g] <= set_i[g] | (pend_o[g] & ~clr_i[g] & ~drop_i[g]);
      end

      assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[g] |=> pend_o[g])
         else $error("set pulse lost on bit %0d", g);

      assert_drop_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (drop_i[g] && !set_i[g]) |=> !pend_o[g])
         else $error("delivery clear ignored on bit %0d", g);
   end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
   import irq_sel_pkg::*;
#(
   parameter int unsigned N       = SRC_N,
   parameter int unsigned CAUSE_W = 4
) (
   input  logic [N-1:0]       pend_i,
   input  logic               crit_en_i,
   input  logic               ext_en_i,
   output logic [N-1:0]       pick_o,
   output logic [CAUSE_W-1:0] cause_o
);

   logic [N-1:0] elig;
   logic [N:0]   above;

   for (genvar g = 0; g < N; g++) begin : g_gate
      if (gate_of(g) == GATE_NONE) begin : g_free
         assign elig[g] = pend_i[g];
      end else if (gate_of(g) == GATE_CRIT) begin : g_crit
         assign elig[g] = pend_i[g] & crit_en_i;
      end else begin : g_ext
         assign elig[g] = pend_i[g] & ext_en_i;
      end
   end

   assign above[0] = 1'b0;
   for (genvar g = 0; g < N; g++) begin : g_chain
      assign above[g+1] = above[g] | elig[g];
      assign pick_o[g]  = elig[g] & ~above[g];
   end

   always_comb begin
      cause_o = '0;
      for (int i = 0; i < N; i++) begin
         if (pick_o[i]) cause_o = cause_o | CAUSE_W'(i);
      end
   end

   always_comb begin
      assert_pick_onehot_R3: assert ($onehot0(pick_o))
         else $error("picker produced several winners");
   end

endmodule

// File: rtl/irq_grant_hold.sv
module irq_grant_hold #(
   parameter int unsigned N       = 12,
   parameter int unsigned CAUSE_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N-1:0]       pick_i,
   input  logic [CAUSE_W-1:0] pick_cause_i,
   input  logic               take_i,
   output logic [N-1:0]       grant_o,
   output logic [CAUSE_W-1:0] cause_o,
   output logic               busy_o
);

   assign busy_o = |grant_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant_o <= '0;
         cause_o <= '0;
      end else if (busy_o) begin
         if (take_i) begin
            grant_o <= '0;
            cause_o <= '0;
         end
      end else begin
         grant_o <= pick_i;
         cause_o <= pick_cause_i;
      end
   end

   assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o))
      else $error("grant not one-hot");

   assert_grant_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !take_i) |=> ($stable(grant_o) && $stable(cause_o)))
      else $error("grant moved without take");

   assert_take_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && take_i) |=> (grant_o == '0))
      else $error("grant survived take");

endmodule

// File: rtl/prio_irq_select.sv
module prio_irq_select
   import irq_sel_pkg::*;
#(
   parameter int unsigned CAUSE_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SRC_N-1:0]   src_set_i,
   input  logic [SRC_N-1:0]   src_clr_i,
   input  logic               take_i,
   input  logic               crit_en_i,
   input  logic               ext_en_i,
   input  logic               decr_clr_cfg_i,
   output logic [SRC_N-1:0]   grant_o,
   output logic [CAUSE_W-1:0] cause_o,
   output logic               req_o
);

   localparam int unsigned IDX_W = $clog2(SRC_N);

   initial begin
      assert_cause_width_R3: assert (CAUSE_W >= IDX_W)
         else $error("CAUSE_W too narrow for %0d sources", SRC_N);
   end

   logic [SRC_N-1:0]   pend;
   logic [SRC_N-1:0]   pick;
   logic [CAUSE_W-1:0] pick_cause;
   logic [SRC_N-1:0]   drop_mask;
   logic [SRC_N-1:0]   drop;
   logic               busy;

   for (genvar g = 0; g < SRC_N; g++) begin : g_drop
      if (drop_of(g) == DROP_NEVER) begin : g_keep
         assign drop_mask[g] = 1'b0;
      end else if (drop_of(g) == DROP_CFG) begin : g_cfg
         assign drop_mask[g] = decr_clr_cfg_i;
      end else begin : g_always
         assign drop_mask[g] = 1'b1;
      end
   end

   assign drop = (busy && take_i) ? (grant_o & drop_mask) : '0;

   irq_pend_bank #(.N(SRC_N)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (src_set_i),
      .clr_i  (src_clr_i),
      .drop_i (drop),
      .pend_o (pend)
   );

   irq_prio_pick #(.N(SRC_N), .CAUSE_W(CAUSE_W)) u_pick (
      .pend_i    (pend),
      .crit_en_i (crit_en_i),
      .ext_en_i  (ext_en_i),
      .pick_o    (pick),
      .cause_o   (pick_cause)
   );

   irq_grant_hold #(.N(SRC_N), .CAUSE_W(CAUSE_W)) u_hold (
      .clk          (clk),
      .rst_n        (rst_n),
      .pick_i       (pick),
      .pick_cause_i (pick_cause),
      .take_i       (take_i),
      .grant_o      (grant_o),
      .cause_o      (cause_o),
      .busy_o       (busy)
   );

   assign req_o = |pend;

   assert_crit_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant_o[IX_CEXT]) |-> $past(crit_en_i))
      else $error("critical input granted while disabled");

   for (genvar g = IX_WDOG; g < SRC_N; g++) begin : g_ext_chk
      assert_ext_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(grant_o[g]) |-> $past(ext_en_i))
         else $error("source %0d granted while external disabled", g);
   end

   assert_sticky_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && (grant_o[IX_CEXT] || grant_o[IX_EXT]) && !(|src_clr_i)) |=> req_o)
      else $error("level source lost on delivery");

   assert_decr_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && grant_o[IX_DECR] && !decr_clr_cfg_i && !src_clr_i[IX_DECR]) |=> req_o)
      else $error("decrementer dropped with clear-on-delivery off");

endmodule

// File: tb/sim_prio_irq_select.sv
module sim_prio_irq_select;
   localparam int CLK_PERIOD = 10;
   localparam int N = 12;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [N-1:0]  src_set_i, src_clr_i;
   logic          take_i, crit_en_i, ext_en_i, decr_clr_cfg_i;
   logic [N-1:0]  grant_o;
   logic [3:0]    cause_o;
   logic          req_o;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   prio_irq_select #(.CAUSE_W(4)) u0 (
      .clk(clk), .rst_n(rst_n), .src_set_i(src_set_i), .src_clr_i(src_clr_i),
      .take_i(take_i), .crit_en_i(crit_en_i), .ext_en_i(ext_en_i),
      .decr_clr_cfg_i(decr_clr_cfg_i), .grant_o(grant_o), .cause_o(cause_o),
      .req_o(req_o)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cleanup();
      src_set_i = '0;
      src_clr_i = '1;
      take_i = 1'b1;
      tick(); tick(); tick();
      src_clr_i = '0;
      take_i = 1'b0;
   endtask

   function automatic bit level_src(input int i);
      return (i == 2) || (i == 8);
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      src_set_i = '0;
      src_clr_i = '0;
      take_i = 1'b0;
      crit_en_i = 1'b1;
      ext_en_i = 1'b1;
      decr_clr_cfg_i = 1'b1;
      tick(); tick();
      rst_n = 1'b1;
      tick();
      check("R1 grant", grant_o, 0);
      check("R1 cause", cause_o, 0);
      check("R1 req", req_o, 0);

      // per-source sweep over enables and decrementer configuration
      for (int cfg = 0; cfg < 2; cfg++) begin
         for (int en = 0; en < 4; en++) begin
            for (int i = 0; i < N; i++) begin
               bit ce, ee, elig, keep;
               ce = en[0];
               ee = en[1];
               crit_en_i = ce;
               ext_en_i = ee;
               decr_clr_cfg_i = cfg[0];
               elig = (i < 2) ? 1'b1 : (i == 2) ? ce : ee;
               keep = level_src(i) || (i == 7 && cfg == 0);
               src_set_i = N'(1) << i;
               tick();
               src_set_i = '0;
               check("R2 req after set", req_o, 1);
               check("R7 no grant yet", grant_o, 0);
               tick();
               check(elig ? "R4 R5 R6 grant" : "R5 R6 gated", grant_o, elig ? (32'd1 << i) : 0);
               check("R3 cause", cause_o, elig ? i : 0);
               if (elig) begin
                  take_i = 1'b1;
                  tick();
                  take_i = 1'b0;
                  check("R8 grant cleared", grant_o, 0);
                  check(keep ? "R9 R10 kept" : "R10 R11 dropped", req_o, keep);
                  tick();
                  check("R8 reselect", grant_o, keep ? (32'd1 << i) : 0);
               end else begin
                  tick();
                  check("R5 R6 still gated", grant_o, 0);
               end
               cleanup();
            end
         end
      end

      // priority over every pair
      crit_en_i = 1'b1;
      ext_en_i = 1'b1;
      decr_clr_cfg_i = 1'b1;
      for (int a = 0; a < N - 1; a++) begin
         for (int b = a + 1; b < N; b++) begin
            src_set_i = (N'(1) << a) | (N'(1) << b);
            tick();
            src_set_i = '0;
            tick();
            check("R3 winner", grant_o, 32'd1 << a);
            check("R3 winner cause", cause_o, a);
            take_i = 1'b1;
            tick();
            take_i = 1'b0;
            tick();
            check("R3 R8 next winner", cause_o, level_src(a) ? a : b);
            cleanup();
         end
      end

      // R7: grant held while a higher source arrives
      src_set_i = N'(1) << 7;
      tick(); src_set_i = '0; tick();
      check("R7 decr granted", grant_o, 32'd1 << 7);
      src_set_i = N'(1);
      tick(); src_set_i = '0; tick();
      check("R7 held", grant_o, 32'd1 << 7);
      take_i = 1'b1; tick(); take_i = 1'b0;
      check("R8 empty after take", grant_o, 0);
      tick();
      check("R8 reset source next", grant_o, 1);
      cleanup();

      // R12: set and take together
      src_set_i = N'(1) << 3;
      tick(); src_set_i = '0; tick();
      check("R12 watchdog granted", grant_o, 32'd1 << 3);
      take_i = 1'b1; src_set_i = N'(1) << 3;
      tick(); take_i = 1'b0; src_set_i = '0;
      check("R12 bit kept", req_o, 1);
      tick();
      check("R12 regranted", grant_o, 32'd1 << 3);
      cleanup();

      // R13: take with no grant, clear versus set
      ext_en_i = 1'b0;
      src_set_i = N'(1) << 5;
      tick(); src_set_i = '0; tick();
      check("R13 no grant", grant_o, 0);
      take_i = 1'b1; tick(); take_i = 1'b0;
      check("R13 stray take ignored", req_o, 1);
      src_set_i = N'(1) << 5; src_clr_i = N'(1) << 5;
      tick(); src_set_i = '0; src_clr_i = '0;
      check("R12 set beats clear", req_o, 1);
      src_clr_i = N'(1) << 5;
      tick(); src_clr_i = '0;
      check("R13 clear pulse", req_o, 0);
      check("R2 req low when empty", req_o, 0);
      cleanup();

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule